// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Generator

This block applies collision-based backpressure on a half-duplex Ethernet link when the receive buffer is close to full. It watches for the start of each incoming frame. When the link is half duplex and the buffer occupancy is strictly above a high-water threshold, it raises a jam request for the transmit path. The transmit path then forces collisions on the wire, which make the far end back off. The block does not form the jam bit pattern, decode addresses or run collision handling. It only decides when a jam starts and how long it lasts.

Two enable bits select the trigger source. The first lets any incoming frame start a jam. The second lets only frames whose destination address matched start one. The jam length comes from a 4-bit code looked up in a nonlinear table of microsecond durations. The code is sampled once, when the jam starts. Time is counted in microsecond ticks from a prescaler of `CLKS_PER_US` clocks. The prescaler restarts at every jam, so each jam lasts a whole number of microseconds.

Top module: `bp_jam_gen`

## Requirements
- R1: The duration code maps to jam lengths as follows: codes 0, 1, 2, 3 and 4 give 5, 10, 15, 25 and 50 µs. Codes 5 through 15 give 100 µs plus 50 µs for each step above 5, up to 600 µs. Code 7 gives 200 µs.
- R2: `jam_on` is never high while `half_duplex` is 0. Dropping `half_duplex` during a jam ends the jam at once, and the jam does not resume when `half_duplex` returns to 1.
- R3: With `mode_any`=1, a `rx_start` pulse starts a jam when the link is half duplex and `fill_level` > `hw_thresh`, whatever the value of `da_match`.
- R4: With `mode_any`=0 and `mode_match`=1, a `rx_start` pulse starts a jam only when `da_match`=1 in the same cycle.
- R5: With both mode bits set, a trigger from either mode starts a jam. With both mode bits cleared, no jam ever starts.
- R6: A frame start with `fill_level` equal to or below `hw_thresh` starts no jam.
- R7: A `rx_start` pulse that arrives while a jam is running neither restarts nor lengthens that jam.
- R8: `dur_code` is sampled in the cycle that starts the jam. Later changes to it do not alter the length of the running jam.
- R9: `jam_on` rises on the clock edge that samples the trigger. It stays high for exactly the selected duration × `CLKS_PER_US` clock cycles.
- R10: A synchronous `rst` clears `jam_on` and `busy` on the next edge, including in the middle of a jam.
- R11: `busy` is high exactly when a jam is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_start | input | 1 | One-cycle pulse at the start of an incoming frame |
| da_match | input | 1 | Destination address of the current frame matched |
| fill_level | input | LVL_W | Current receive-buffer occupancy |
| hw_thresh | input | LVL_W | Backpressure high-water threshold |
| half_duplex | input | 1 | 1 = half-duplex link; backpressure is allowed only in this mode |
| mode_any | input | 1 | Any frame may start a jam |
| mode_match | input | 1 | An address-matched frame may start a jam |
| dur_code | input | 4 | Jam duration code |
| jam_on | output | 1 | Jam request to the transmit path |
| busy | output | 1 | A jam is in progress |

## Verification
The hardest situations to reach are the ones inside a running jam: a second frame start arriving, the duration code changing, the duplex mode dropping, or a reset. Each of these must act on a jam that is already counting down. The bench starts a jam and keeps counting cycles while `jam_on` is high. At a chosen cycle inside that window it injects the disturbance. It then compares the measured length against the length computed from the code sampled at the start. Full-length jams for all sixteen codes are covered by the vector table, with a reduced prescaler so that the longest code stays short.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int unsigned CODE_W = 4;
    localparam int unsigned DUR_W  = 10;   // holds up to 600 us

    typedef logic [CODE_W-1:0] dur_code_t;
    typedef logic [DUR_W-1:0]  dur_us_t;

    typedef struct packed {
        logic      fire;
        dur_code_t code;
    } jam_req_t;

    // Microsecond length for each duration code
    function automatic dur_us_t code_to_us(input dur_code_t c);
        dur_us_t r;
        case (c)
            4'd0:    r = dur_us_t'(5);
            4'd1:    r = dur_us_t'(10);
            4'd2:    r = dur_us_t'(15);
            4'd3:    r = dur_us_t'(25);
            4'd4:    r = dur_us_t'(50);
            default: r = dur_us_t'(100) + dur_us_t'(50) * dur_us_t'(c - 4'd5);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bp_us_tick.sv
module bp_us_tick #(
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    generate
        if (CLKS_PER_US == 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == CW'(CLKS_PER_US - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = run && (cnt == CW'(CLKS_PER_US - 1));

            // R9: ticks are spaced by the full divider period
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/bp_trigger.sv
module bp_trigger
    import bp_pkg::*;
#(
    parameter int unsigned LVL_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             da_match,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] hw_thresh,
    input  logic             half_duplex,
    input  logic             mode_any,
    input  logic             mode_match,
    input  dur_code_t        dur_code,
    input  logic             busy,
    output jam_req_t         req
);
    logic over_hw;
    logic src_ok;

    assign over_hw = fill_level > hw_thresh;
    assign src_ok  = mode_any || (mode_match && da_match);

    always_comb begin
        req.fire = rx_start && half_duplex && over_hw && src_ok && !busy;
        req.code = dur_code;
    end

    // R6: a request is only raised above the high-water mark
    fire_over_hw_chk: assert property (@(posedge clk) disable iff (rst)
        req.fire |-> (fill_level > hw_thresh) && rx_start);
endmodule

// File: rtl/bp_jam_timer.sv
module bp_jam_timer
    import bp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  jam_req_t req,
    input  logic     half_duplex,
    input  logic     tick,
    output logic     active
);
    dur_us_t remaining;

    always_ff @(posedge clk) begin
        if (rst || !half_duplex) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (!active && req.fire) begin
            active    <= 1'b1;
            remaining <= code_to_us(req.code);
        end else if (active && tick) begin
            if (remaining == dur_us_t'(1)) begin
                active    <= 1'b0;
                remaining <= '0;
            end else begin
                remaining <= remaining - 1'b1;
            end
        end
    end

    // R2
    // Nothing runs after a full-duplex cycle.
    fdx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(half_duplex) |-> !active);

    // R7
    // A running jam never gains time.
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $past(active) && active |-> remaining <= $past(remaining));

    // R9
    // A normal end follows the last tick.
    clean_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) && !$past(rst) && $past(half_duplex)
        |-> $past(tick) && ($past(remaining) == dur_us_t'(1)));

    // R1
    // The remaining count stays inside the table range.
    range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (remaining >= dur_us_t'(1)) && (remaining <= dur_us_t'(600)));
endmodule

// File: rtl/bp_jam_gen.sv
module bp_jam_gen
    import bp_pkg::*;
#(
    parameter int unsigned LVL_W       = 14,
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             da_match,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] hw_thresh,
    input  logic             half_duplex,
    input  logic             mode_any,
    input  logic             mode_match,
    input  logic [3:0]       dur_code,
    output logic             jam_on,
    output logic             busy
);
    jam_req_t req;
    logic     active;
    logic     tick;

    bp_trigger #(.LVL_W(LVL_W)) u_trig (
        .clk(clk), .rst(rst), .rx_start(rx_start), .da_match(da_match),
        .fill_level(fill_level), .hw_thresh(hw_thresh),
        .half_duplex(half_duplex), .mode_any(mode_any), .mode_match(mode_match),
        .dur_code(dur_code_t'(dur_code)), .busy(active), .req(req)
    );

    bp_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk(clk), .rst(rst), .run(active), .tick(tick)
    );

    bp_jam_timer u_timer (
        .clk(clk), .rst(rst), .req(req), .half_duplex(half_duplex),
        .tick(tick), .active(active)
    );

    assign jam_on = active && half_duplex;
    assign busy   = active;

    // R10
    // Reset leaves the block idle.
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !jam_on && !busy);
endmodule

// File: tb/bp_jam_gen_test.sv
module bp_jam_gen_test;
    localparam int LVL_W = 14;
    localparam int CPU   = 4;
    localparam logic [LVL_W-1:0] THR = 14'd3072;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_start = 1'b0, da_match = 1'b0, half_duplex = 1'b1;
    logic mode_any = 1'b0, mode_match = 1'b0;
    logic [LVL_W-1:0] fill_level = '0, hw_thresh = THR;
    logic [3:0] dur_code = 4'd7;
    logic jam_on, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    bp_jam_gen #(.LVL_W(LVL_W), .CLKS_PER_US(CPU)) uut (
        .clk(clk), .rst(rst), .rx_start(rx_start), .da_match(da_match),
        .fill_level(fill_level), .hw_thresh(hw_thresh),
        .half_duplex(half_duplex), .mode_any(mode_any), .mode_match(mode_match),
        .dur_code(dur_code), .jam_on(jam_on), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int want_us(input logic [3:0] c);
        int t [0:4] = '{5, 10, 15, 25, 50};
        if (c < 4'd5) return t[c];
        return 100 + 50 * (int'(c) - 5);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse rx_start, then count jam cycles. Inside the jam, at cycle
    // 'poke', a disturbance is applied: 1 = repulse, 2 = new code,
    // 3 = drop duplex, 4 = reset.
    task automatic run_jam(input int poke, input int kind, output int len);
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        len = 0;
        while (jam_on && len < 3000) begin
            len++;
            if (busy !== jam_on) check("R11 busy", int'(busy), int'(jam_on));
            if (len == poke) begin
                case (kind)
                    1: rx_start = 1'b1;
                    2: dur_code = ~dur_code;
                    3: half_duplex = 1'b0;
                    4: rst = 1'b1;
                    default: ;
                endcase
            end
            @(negedge clk);
            rx_start = 1'b0;
            rst = 1'b0;
        end
    endtask

    // {code, any, match, da, hd, above, expect_jam}
    localparam int NV = 24;
    localparam logic [9:0] VEC [0:NV-1] = '{
        {4'd0, 6'b100111}, {4'd1, 6'b100111}, {4'd2, 6'b100111}, {4'd3, 6'b100111},
        {4'd4, 6'b100111}, {4'd5, 6'b100111}, {4'd6, 6'b100111}, {4'd7, 6'b100111},
        {4'd8, 6'b100111}, {4'd9, 6'b100111}, {4'd10, 6'b100111}, {4'd11, 6'b100111},
        {4'd12, 6'b101111}, {4'd13, 6'b101111}, {4'd14, 6'b101111}, {4'd15, 6'b101111},
        {4'd0, 6'b100010}, {4'd1, 6'b100100}, {4'd1, 6'b010110}, {4'd1, 6'b011111},
        {4'd2, 6'b110111}, {4'd2, 6'b111111}, {4'd2, 6'b001110}, {4'd0, 6'b000110}
    };

    initial begin
        int len;
        repeat (3) @(negedge clk);
        check("R10 reset jam_on", int'(jam_on), 0);
        check("R10 reset busy", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            int exp;
            v = VEC[i];
            dur_code    = v[9:6];
            mode_any    = v[5];
            mode_match  = v[4];
            da_match    = v[3];
            half_duplex = v[2];
            fill_level  = v[1] ? THR + 1'b1 : THR;
            exp = v[0] ? want_us(v[9:6]) * CPU : 0;
            run_jam(0, 0, len);
            // R1 R3 R4 R5 R6 R2 R9
            check($sformatf("R1/R9 vector %0d length", i), len, exp);
            half_duplex = 1'b1;
            repeat (2) @(negedge clk);
        end

        mode_any = 1'b1; mode_match = 1'b0; half_duplex = 1'b1;
        fill_level = THR + 1'b1;

        // R7: repulse during jam
        dur_code = 4'd2;
        run_jam(20, 1, len);
        check("R7 repulse ignored", len, 15 * CPU);

        // R8: code change mid-jam
        dur_code = 4'd1;
        run_jam(5, 2, len);
        check("R8 code sampled at start", len, 10 * CPU);
        dur_code = 4'd1;

        // R2: drop duplex mid-jam, jam ends at once and stays off
        dur_code = 4'd4;
        run_jam(30, 3, len);
        check("R2 duplex drop length", len, 30);
        half_duplex = 1'b1;
        @(negedge clk);
        check("R2 no resume", int'(jam_on), 0);

        // R10: reset mid-jam
        run_jam(12, 4, len);
        check("R10 reset mid-jam", len, 12);
        check("R10 busy after reset", int'(busy), 0);

        // R9: new jam works after those events
        dur_code = 4'd0;
        run_jam(0, 0, len);
        check("R9 later jam", len, 5 * CPU);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule